// File: doc/BRIEF.md
# Divided Countdown Timer with Interrupt Entry

This block is a 32-bit down-counting timer. Its time base is the bus clock divided by a programmable power of two. Software writes an initial count, which restarts the countdown. It can read back the running count at any time. A single interrupt entry sets the interrupt vector, a mask bit and the choice between periodic and one-shot operation.

When a period elapses and the entry permits it, the block emits a request toward an interrupt arbiter. The request is a pulse one clock long and carries the programmed vector.

The mask does not stop the count. It only decides whether an expiry raises a request, and whether the timer stays armed after it. Clearing the mask, or switching from periodic to one-shot, changes the arming state. The rules for this follow the timer's position in its schedule: the timer stays on the grid of period boundaries that began at the last load.

Top module: `lapic_timer`

## Requirements
- R1: After reset the entry word reads 0x0001_0000 (masked, one-shot, vector 0). Initial count, current count and divide word all read 0, and no request is raised.
- R2: The register map is: address 0 is the entry (vector in bits 7:0, mask in bit 16, periodic in bit 17); address 1 is the initial count; address 2 is the current count (read-only); address 3 is the divide word. The entry and divide word read back only their defined bits, and every other bit reads 0.
- R3: The divide word uses bits {3,1,0} as a 3-bit code. Codes 0 to 6 divide the clock by 2, 4, 8, 16, 32, 64 and 128, and code 7 divides by 1. The first divided tick after a load falls on the D-th clock edge after the load edge, where D is the divide ratio.
- R4: In periodic mode, after n divided ticks the current count reads IC − (n mod (IC+1)), where IC is the initial count. An expiry occurs at every n that is a multiple of IC+1. When armed and unmasked, the request output goes high for exactly one cycle after the expiry edge and carries the entry's vector.
- R5: In one-shot mode the current count reads 0 once n ≥ IC. The timer fires once, at n = IC+1, and never again until the next load.
- R6: Writing the initial count arms the timer only if the entry is unmasked and the value is nonzero. A zero initial count never raises a request.
- R7: Masking does not stop the count. An expiry while masked raises no request.
- R8: Clearing the mask while the timer is disarmed and the initial count is nonzero rearms the timer. In periodic mode it fires on the next multiple of IC+1 ticks since the load. In one-shot mode it fires at the original end point, and only if that point has not yet passed.
- R9: Switching from periodic to one-shot after the first expiry stops the timer. Inside the first period the timer still fires once.
- R10: An entry write that changes neither mask nor periodic does not move the schedule. A new vector takes effect at the next expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
A register write takes effect at the clock edge where it is sampled. That edge is counted as edge 0 of the schedule.

The current count is combinational, so its value after edge k is read half a cycle later. The request is registered. It is high in the cycle after edge (IC+1)·D and is checked at that same half-cycle point, in both the cycle before and the cycle after, to pin it to one cycle.

Rearming and mode changes are checked by where the next pulse lands. A running pulse counter, sampled on falling edges, confirms that no extra pulse appears.

// File: rtl/lapic_timer.sv
module lapic_timer #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8,
  parameter int PRE_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  localparam logic [1:0] A_ENTRY = 2'd0, A_INIT = 2'd1, A_CUR = 2'd2, A_DIV = 2'd3;

  logic [VEC_W-1:0] vec_q;
  logic             mask_q, per_q, first_q, armed_q;
  logic [2:0]       dcode_q;
  logic [CNT_W-1:0] ic_q, ph_q, cur;
  logic [PRE_W-1:0] pre_q, pre_lim;
  logic [2:0]       shift;
  logic             tick, wrap, ic_nz;
  logic             ent_wr, init_wr, div_wr, new_mask, new_per;

  assign shift   = (dcode_q == 3'd7) ? 3'd0 : dcode_q + 3'd1;
  assign pre_lim = (PRE_W'(1) << shift) - PRE_W'(1);
  assign tick    = pre_q >= pre_lim;
  assign ic_nz   = ic_q != '0;
  assign wrap    = tick && ic_nz && ph_q == '0;
  assign cur     = (!per_q && !first_q) ? '0 : ph_q;

  assign ent_wr   = reg_we && reg_addr == A_ENTRY;
  assign init_wr  = reg_we && reg_addr == A_INIT;
  assign div_wr   = reg_we && reg_addr == A_DIV;
  assign new_mask = reg_wdata[16];
  assign new_per  = reg_wdata[17];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q      <= '0;
      mask_q     <= 1'b1;
      per_q      <= 1'b0;
      dcode_q    <= '0;
      ic_q       <= '0;
      ph_q       <= '0;
      first_q    <= 1'b0;
      armed_q    <= 1'b0;
      pre_q      <= '0;
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid  <= wrap && armed_q && !mask_q && (per_q || first_q);
      irq_vector <= vec_q;
      pre_q      <= tick ? '0 : pre_q + PRE_W'(1);
      if (tick && ic_nz) begin
        ph_q <= (ph_q == '0) ? ic_q : ph_q - CNT_W'(1);
      end
      if (wrap) begin
        first_q <= 1'b0;
        armed_q <= armed_q && !mask_q && per_q;
      end
      if (init_wr) begin
        ic_q    <= CNT_W'(reg_wdata);
        ph_q    <= CNT_W'(reg_wdata);
        pre_q   <= '0;
        first_q <= 1'b1;
        armed_q <= !mask_q && reg_wdata != '0;
      end
      if (ent_wr) begin
        vec_q  <= reg_wdata[VEC_W-1:0];
        mask_q <= new_mask;
        per_q  <= new_per;
        if (per_q && !new_per && !first_q)
          armed_q <= 1'b0;
        else if (mask_q && !new_mask && !armed_q && ic_nz)
          armed_q <= new_per || first_q;
      end
      if (div_wr) dcode_q <= {reg_wdata[3], reg_wdata[1:0]};
    end
  end

  always_comb begin
    case (reg_addr)
      A_ENTRY: reg_rdata = {14'd0, per_q, mask_q, 8'd0, 8'(vec_q)};
      A_INIT:  reg_rdata = 32'(ic_q);
      A_CUR:   reg_rdata = 32'(cur);
      default: reg_rdata = {28'd0, dcode_q[2], 1'b0, dcode_q[1:0]};
    endcase
  end
endmodule

module lapic_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_valid,
  input logic             mask_q,
  input logic [CNT_W-1:0] ic_q,
  input logic [CNT_W-1:0] cur
);
  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(mask_q));
  // R4
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid);
  // R6
  irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(ic_q) != '0);
  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur <= ic_q);
endmodule

bind lapic_timer lapic_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid),
  .mask_q(mask_q), .ic_q(ic_q), .cur(cur)
);

// File: tb/tb_lapic_timer.sv
module tb_lapic_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  int checks = 0, fails = 0, pulses = 0;
  bit done = 1'b0;

  lapic_timer dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  always #10 clk = ~clk;
  always @(negedge clk) if (rst_n && irq_valid) pulses++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd0, v); chk("R1 entry", v, 32'h0001_0000);
    rd(2'd1, v); chk("R1 init", v, 0);
    rd(2'd2, v); chk("R1 current", v, 0);
    rd(2'd3, v); chk("R1 divide", v, 0);
    chk("R1 irq", 32'(irq_valid), 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); chk("R2 divide bits", v, 32'hB);
    wr(2'd3, 32'h4);         rd(2'd3, v); chk("R2 divide bit2 ignored", v, 0);
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); chk("R2 entry bits", v, 32'h0003_00FF);
    wr(2'd0, 32'h0001_0000);
  endtask

  task automatic t_periodic;
    logic [31:0] v; int base;
    wr(2'd0, 32'h0002_0041); wr(2'd3, 32'hB);
    base = pulses;
    wr(2'd1, 3);
    edges(1); rd(2'd2, v); chk("R4 count n=1", v, 2);
    edges(2); rd(2'd2, v); chk("R4 count n=3", v, 0);
    chk("R4 no irq before expiry", 32'(irq_valid), 0);
    edges(1); chk("R4 irq at IC+1", 32'(irq_valid), 1);
    chk("R4 vector", 32'(irq_vector), 32'h41);
    rd(2'd2, v); chk("R4 count reload", v, 3);
    edges(1); chk("R4 one-cycle pulse", 32'(irq_valid), 0);
    edges(8); chk("R4 periodic pulse count", 32'(pulses - base), 3);
  endtask

  task automatic t_div;
    logic [31:0] v;
    wr(2'd0, 32'h0003_0000);
    wr(2'd3, 32'h2); wr(2'd1, 2);
    edges(7); rd(2'd2, v); chk("R3 div8 before tick", v, 2);
    edges(1); rd(2'd2, v); chk("R3 div8 first tick", v, 1);
    wr(2'd3, 32'h8); wr(2'd1, 5);
    edges(31); rd(2'd2, v); chk("R3 div32 before tick", v, 5);
    edges(1);  rd(2'd2, v); chk("R3 div32 first tick", v, 4);
    wr(2'd3, 32'h0); wr(2'd1, 5);
    edges(1); rd(2'd2, v); chk("R3 div2 before tick", v, 5);
    edges(1); rd(2'd2, v); chk("R3 div2 first tick", v, 4);
  endtask

  task automatic t_oneshot;
    logic [31:0] v; int base;
    wr(2'd0, 32'h0000_0042); wr(2'd3, 32'hB);
    base = pulses;
    wr(2'd1, 3);
    edges(3); rd(2'd2, v); chk("R5 reads zero at IC", v, 0);
    chk("R5 no irq at IC", 32'(irq_valid), 0);
    edges(1); chk("R5 fires at IC+1", 32'(irq_valid), 1);
    edges(10); chk("R5 fires once", 32'(pulses - base), 1);
    rd(2'd2, v); chk("R5 stays zero", v, 0);
  endtask

  task automatic t_zero_masked;
    logic [31:0] v; int base;
    wr(2'd0, 32'h0002_0043);
    base = pulses;
    wr(2'd1, 0);
    edges(10); chk("R6 zero count no irq", 32'(pulses - base), 0);
    rd(2'd2, v); chk("R6 zero count reads 0", v, 0);
    wr(2'd0, 32'h0003_0043);
    base = pulses;
    wr(2'd1, 2);
    edges(10); chk("R6 masked load no irq", 32'(pulses - base), 0);
    rd(2'd2, v); chk("R7 masked still counts", v, 1);
    wr(2'd0, 32'h0002_0043);
    chk("R8 no irq before boundary", 32'(irq_valid), 0);
    edges(1); chk("R8 periodic rearm on boundary", 32'(irq_valid), 1);
  endtask

  task automatic t_mask_expiry;
    logic [31:0] v; int base;
    wr(2'd0, 32'h0002_0044);
    base = pulses;
    wr(2'd1, 2);
    wr(2'd0, 32'h0003_0044);
    edges(8); chk("R7 masked expiry no irq", 32'(pulses - base), 0);
    rd(2'd2, v); chk("R7 count runs while masked", v, 2);
  endtask

  task automatic t_unmask_oneshot;
    int base;
    wr(2'd0, 32'h0001_0045);
    base = pulses;
    wr(2'd1, 4);
    wr(2'd0, 32'h0000_0045);
    edges(3); chk("R8 one-shot not early", 32'(irq_valid), 0);
    edges(1); chk("R8 one-shot original end", 32'(irq_valid), 1);
    edges(6); chk("R8 one-shot once", 32'(pulses - base), 1);
    wr(2'd0, 32'h0001_0045);
    base = pulses;
    wr(2'd1, 1);
    edges(4);
    wr(2'd0, 32'h0000_0045);
    edges(6); chk("R8 one-shot end passed", 32'(pulses - base), 0);
  endtask

  task automatic t_per_to_one;
    logic [31:0] v; int base;
    wr(2'd0, 32'h0002_0046);
    base = pulses;
    wr(2'd1, 2);
    edges(4); chk("R9 first period fired", 32'(pulses - base), 1);
    wr(2'd0, 32'h0000_0046);
    rd(2'd2, v); chk("R9 stopped reads 0", v, 0);
    edges(9); chk("R9 stopped after first", 32'(pulses - base), 1);
    wr(2'd0, 32'h0002_0047);
    base = pulses;
    wr(2'd1, 5);
    wr(2'd0, 32'h0000_0047);
    edges(4); chk("R9 within first no early", 32'(irq_valid), 0);
    edges(1); chk("R9 within first fires", 32'(irq_valid), 1);
    edges(12); chk("R9 within first once", 32'(pulses - base), 1);
  endtask

  task automatic t_other_bits;
    wr(2'd0, 32'h0002_0048);
    wr(2'd1, 3);
    wr(2'd0, 32'h0002_0055);
    edges(2); chk("R10 schedule kept early", 32'(irq_valid), 0);
    edges(1); chk("R10 schedule kept fire", 32'(irq_valid), 1);
    chk("R10 new vector", 32'(irq_vector), 32'h55);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    edges(1);
    t_reset();
    t_regs();
    t_periodic();
    t_div();
    t_oneshot();
    t_zero_masked();
    t_mask_expiry();
    t_unmask_oneshot();
    t_per_to_one();
    t_other_bits();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule